// File: doc/BRIEF.md
# Per-Register Busy-Bit Hazard Scoreboard

This block tracks which architectural registers have a write still outstanding in the pipeline. It holds a single pending-write flag per register instead of a queue of destination tags. The decode stage presents up to two source operands and one destination operand, each with its own valid flag. The block answers in the same cycle with one stall signal. Stall is raised when a valid source names a register that is still pending (read-after-write). It is also raised when the valid destination names a register that is still pending (write-after-write). A single flag cannot count two writers to the same register, so the block never lets two such writers be in flight at once.

When decode requests issue and stall is low, the destination's flag is set at the next clock edge. When an instruction commits, its destination's flag is cleared. That clear already applies to the queries of the same cycle, so a dependent instruction waiting in decode can leave on the commit cycle. Register 0 is hardwired and is never tracked. Decode, the register file and forwarding live elsewhere.

Top module: `busy_scoreboard`

## Requirements
- R1: After reset no register is pending, so every query returns stall low.
- R2: With `src_a_vld` high and `src_a_idx` naming a pending register that is not being committed this cycle, `stall` is high in the same cycle.
- R3: With `src_b_vld` high and `src_b_idx` naming a pending register that is not being committed this cycle, `stall` is high in the same cycle.
- R4: With `dst_vld` high and `dst_idx` naming a pending register that is not being committed this cycle, `stall` is high (write-after-write).
- R5: An operand whose valid flag is low never raises `stall`, whatever its index.
- R6: Register index 0 is never made pending by an issue, and a query on index 0 never raises `stall`.
- R7: When `issue_req` and `dst_vld` are high and `stall` is low, register `dst_idx` is pending from the next cycle on.
- R8: When `issue_req` is high and `stall` is high, no register becomes pending.
- R9: When `commit_en` is high, register `commit_idx` is treated as free by that same cycle's queries and is not pending in the next cycle, unless it is re-issued in that cycle.
- R10: If one register is committed and issued in the same cycle, it ends the cycle pending.
- R11: Under any mix of issues, commits and queries, `stall` equals the OR of the three operand hits against the per-register pending state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_vld | input | 1 | First source operand present |
| src_a_idx | input | IDX_W | First source register number |
| src_b_vld | input | 1 | Second source operand present |
| src_b_idx | input | IDX_W | Second source register number |
| dst_vld | input | 1 | Destination operand present |
| dst_idx | input | IDX_W | Destination register number |
| issue_req | input | 1 | Decode wants to admit its instruction to execute |
| commit_en | input | 1 | An instruction commits this cycle |
| commit_idx | input | IDX_W | Destination register of the committing instruction |
| stall | output | 1 | Decode must hold its instruction |

## Verification
Several corner cases get directed tests. A commit and a dependent read in the same cycle must not stall. A design that used the registered flags would hold decode for an extra cycle. A commit and a re-issue of the same register must leave that register pending. A design that gave priority to the clear would lose the new writer and let a later reader through too early. An issue attempted while stalled must leave no trace. If the set were not gated, a later write-after-write check on that destination would fire. Register 0 and invalid operands are also probed, because a design that ignored these would stall on them. A long pseudo-random run then compares `stall` with a behavioural model on every cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int unsigned SB_REGS   = 32;
    localparam int unsigned SB_PROBES = 3;

    typedef enum logic [1:0] {
        PROBE_SRC_A = 2'd0,
        PROBE_SRC_B = 2'd1,
        PROBE_DEST  = 2'd2
    } probe_role_e;

endpackage

// File: rtl/sb_onehot.sv
module sb_onehot #(
    parameter int unsigned N = 32,
    parameter int unsigned W = 5
) (
    input  logic         en,
    input  logic [W-1:0] idx,
    output logic [N-1:0] mask
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == 0) begin : g_zero
            assign mask[i] = 1'b0;          // register 0 is never tracked
        end else begin : g_live
            assign mask[i] = en && (idx == W'(i));
        end
    end

endmodule

// File: rtl/sb_bit_array.sv
module sb_bit_array #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] set_mask,
    output logic [N-1:0] busy_q,
    output logic [N-1:0] busy_eff
);

    // Clears take effect for the current cycle's queries.
    assign busy_eff = busy_q & ~clr_mask;

    // A set in the same cycle as a clear of the same bit wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            busy_q <= busy_eff | set_mask;
        end
    end

endmodule

// File: rtl/sb_probe.sv
module sb_probe #(
    parameter int unsigned N = 32,
    parameter int unsigned W = 5
) (
    input  logic         vld,
    input  logic [W-1:0] idx,
    input  logic [N-1:0] busy_eff,
    output logic         hit
);

    localparam int unsigned SPAN = 1 << W;

    logic [SPAN-1:0] padded;

    assign padded = SPAN'(busy_eff);
    assign hit    = vld && (idx != '0) && padded[idx];

endmodule

// File: rtl/busy_scoreboard.sv
module busy_scoreboard
    import sb_pkg::*;
#(
    parameter  int unsigned NUM_REGS = SB_REGS,
    localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_a_vld,
    input  logic [IDX_W-1:0] src_a_idx,
    input  logic             src_b_vld,
    input  logic [IDX_W-1:0] src_b_idx,
    input  logic             dst_vld,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic             issue_req,
    input  logic             commit_en,
    input  logic [IDX_W-1:0] commit_idx,
    output logic             stall
);

    logic [NUM_REGS-1:0]  busy_q;
    logic [NUM_REGS-1:0]  busy_eff;
    logic [NUM_REGS-1:0]  set_mask;
    logic [NUM_REGS-1:0]  clr_mask;
    logic                 issue_fire;

    logic                 probe_vld [SB_PROBES];
    logic [IDX_W-1:0]     probe_idx [SB_PROBES];
    logic [SB_PROBES-1:0] probe_hit;

    assign probe_vld[PROBE_SRC_A] = src_a_vld;
    assign probe_idx[PROBE_SRC_A] = src_a_idx;
    assign probe_vld[PROBE_SRC_B] = src_b_vld;
    assign probe_idx[PROBE_SRC_B] = src_b_idx;
    assign probe_vld[PROBE_DEST]  = dst_vld;
    assign probe_idx[PROBE_DEST]  = dst_idx;

    for (genvar p = 0; p < SB_PROBES; p++) begin : g_probe
        sb_probe #(
            .N (NUM_REGS),
            .W (IDX_W)
        ) u_probe (
            .vld      (probe_vld[p]),
            .idx      (probe_idx[p]),
            .busy_eff (busy_eff),
            .hit      (probe_hit[p])
        );
    end

    assign stall      = |probe_hit;
    assign issue_fire = issue_req && dst_vld && !stall;

    sb_onehot #(
        .N (NUM_REGS),
        .W (IDX_W)
    ) u_set_dec (
        .en   (issue_fire),
        .idx  (dst_idx),
        .mask (set_mask)
    );

    sb_onehot #(
        .N (NUM_REGS),
        .W (IDX_W)
    ) u_clr_dec (
        .en   (commit_en),
        .idx  (commit_idx),
        .mask (clr_mask)
    );

    sb_bit_array #(
        .N (NUM_REGS)
    ) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_mask (clr_mask),
        .set_mask (set_mask),
        .busy_q   (busy_q),
        .busy_eff (busy_eff)
    );

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int unsigned N = 32,
    parameter int unsigned W = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         src_a_vld,
    input logic [W-1:0] src_a_idx,
    input logic         src_b_vld,
    input logic [W-1:0] src_b_idx,
    input logic         dst_vld,
    input logic [W-1:0] dst_idx,
    input logic         issue_req,
    input logic         commit_en,
    input logic [W-1:0] commit_idx,
    input logic         stall,
    input logic [N-1:0] busy_q
);

    localparam int unsigned SPAN = 1 << W;

    logic [SPAN-1:0] bq;
    assign bq = SPAN'(busy_q);

    a_r2_src_a_hazard: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_vld && src_a_idx != '0 && bq[src_a_idx]
         && !(commit_en && commit_idx == src_a_idx)) |-> stall);

    a_r3_src_b_hazard: assert property (@(posedge clk) disable iff (!rst_n)
        (src_b_vld && src_b_idx != '0 && bq[src_b_idx]
         && !(commit_en && commit_idx == src_b_idx)) |-> stall);

    a_r4_dest_hazard: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_vld && dst_idx != '0 && bq[dst_idx]
         && !(commit_en && commit_idx == dst_idx)) |-> stall);

    a_r5_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_a_vld && !src_b_vld && !dst_vld) |-> !stall);

    a_r6_zero_free: assert property (@(posedge clk) disable iff (!rst_n)
        !bq[0]);

    a_r7_issue_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_req && dst_vld && !stall && dst_idx != '0) |=> bq[$past(dst_idx)]);

    a_r8_stalled_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_req && dst_vld && stall && dst_idx != '0 && !bq[dst_idx])
        |=> !bq[$past(dst_idx)]);

    a_r9_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && commit_idx != '0
         && !(issue_req && dst_vld && !stall && dst_idx == commit_idx))
        |=> !bq[$past(commit_idx)]);

endmodule

bind busy_scoreboard sb_checker #(
    .N (NUM_REGS),
    .W (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_a_vld  (src_a_vld),
    .src_a_idx  (src_a_idx),
    .src_b_vld  (src_b_vld),
    .src_b_idx  (src_b_idx),
    .dst_vld    (dst_vld),
    .dst_idx    (dst_idx),
    .issue_req  (issue_req),
    .commit_en  (commit_en),
    .commit_idx (commit_idx),
    .stall      (stall),
    .busy_q     (busy_q)
);

// File: tb/busy_scoreboard_tb.sv
module busy_scoreboard_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 20000;
    localparam int NREG       = 32;
    localparam int IW         = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          src_a_vld = 1'b0, src_b_vld = 1'b0, dst_vld = 1'b0;
    logic [IW-1:0] src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
    logic          issue_req = 1'b0, commit_en = 1'b0;
    logic [IW-1:0] commit_idx = '0;
    logic          stall;

    int checks = 0;
    int fails  = 0;
    bit pending [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    busy_scoreboard u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_a_vld  (src_a_vld),
        .src_a_idx  (src_a_idx),
        .src_b_vld  (src_b_vld),
        .src_b_idx  (src_b_idx),
        .dst_vld    (dst_vld),
        .dst_idx    (dst_idx),
        .issue_req  (issue_req),
        .commit_en  (commit_en),
        .commit_idx (commit_idx),
        .stall      (stall)
    );

    function automatic bit model_hit(bit v, int r, bit ce, int ci);
        if (!v || r == 0) return 1'b0;
        if (ce && ci == r) return 1'b0;
        return pending[r];
    endfunction

    task automatic step(string tag, bit av, int ai, bit bv, int bi,
                        bit dv, int di, bit iss, bit ce, int ci);
        bit exp;
        @(negedge clk);
        src_a_vld = av; src_a_idx = IW'(ai);
        src_b_vld = bv; src_b_idx = IW'(bi);
        dst_vld   = dv; dst_idx   = IW'(di);
        issue_req = iss; commit_en = ce; commit_idx = IW'(ci);
        #1;
        exp = model_hit(av, ai, ce, ci) || model_hit(bv, bi, ce, ci)
           || model_hit(dv, di, ce, ci);
        checks++;
        if (stall !== exp) begin
            fails++;
            $display("FAIL %s: stall=%b expected %b (a=%0d/%0d b=%0d/%0d d=%0d/%0d iss=%0d c=%0d/%0d)",
                     tag, stall, exp, av, ai, bv, bi, dv, di, iss, ce, ci);
        end
        @(posedge clk);
        if (ce) pending[ci] = 1'b0;
        if (iss && dv && !exp && di != 0) pending[di] = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        finish_run();
    end

    initial begin
        foreach (pending[i]) pending[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: nothing pending after reset
        for (int r = 0; r < NREG; r++)
            step("R1", 1, r, 1, (r + 7) % NREG, 1, (r + 13) % NREG, 0, 0, 0);

        // R7: issue to 5 with no hazard
        step("R7", 0, 0, 0, 0, 1, 5, 1, 0, 0);
        // R2 / R3 / R4 against pending 5
        step("R2", 1, 5, 0, 0, 0, 0, 0, 0, 0);
        step("R3", 0, 0, 1, 5, 0, 0, 0, 0, 0);
        step("R4", 0, 0, 0, 0, 1, 5, 0, 0, 0);
        // R5: invalid operands naming 5
        step("R5", 0, 5, 0, 5, 0, 5, 1, 0, 0);
        // R6: issue to register 0, then query it
        step("R6", 0, 0, 0, 0, 1, 0, 1, 0, 0);
        step("R6", 1, 0, 1, 0, 1, 0, 0, 0, 0);
        // R8: issue to 7 while stalled on source 5, then probe 7
        step("R8", 1, 5, 0, 0, 1, 7, 1, 0, 0);
        step("R8", 0, 0, 0, 0, 1, 7, 0, 0, 0);
        step("R8", 1, 7, 1, 7, 0, 0, 0, 0, 0);
        // R9: commit 5 with a reader of 5 in the same cycle
        step("R9", 1, 5, 0, 0, 0, 0, 0, 1, 5);
        step("R9", 1, 5, 1, 5, 1, 5, 0, 0, 0);
        // R10: make 9 pending, then commit and reissue 9 together
        step("R10", 0, 0, 0, 0, 1, 9, 1, 0, 0);
        step("R10", 0, 0, 0, 0, 1, 9, 1, 1, 9);
        step("R10", 1, 9, 0, 0, 0, 0, 0, 0, 0);
        step("R10", 0, 0, 0, 0, 0, 0, 0, 1, 9);
        step("R10", 0, 0, 1, 9, 0, 0, 0, 0, 0);

        // R11: pseudo-random traffic on a small register window
        for (int n = 0; n < 3000; n++) begin
            step("R11",
                 1'($urandom_range(0, 1)), $urandom_range(0, 7),
                 1'($urandom_range(0, 1)), $urandom_range(0, 7),
                 1'($urandom_range(0, 1)), $urandom_range(0, 7),
                 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 9) < 4), $urandom_range(0, 7));
        end

        finish_run();
    end

endmodule